// File: doc/BRIEF.md
# Block-Cipher FIFO Dispatch Controller

This block sits in front of a block-cipher engine. Software-side logic pushes 32-bit words into an 8-deep input queue and pops results from an 8-deep output queue. The controller hands a block to the engine only when two conditions hold: the input queue holds a whole block, and the output queue has room for a whole block. A block is two words when 64-bit blocks are selected and four words when 128-bit blocks are selected. A busy flag covers every cycle in which a block is loaded, computed or stored. It also covers a key-preparation pass that runs before the first decryption with 128-bit blocks.

The engine is a stub with a start/done handshake and a fixed latency. Its stand-in result is each input word XORed with a mask: the mask itself for encryption and its complement for decryption. The configuration fields that select block size, direction, key size and data layout are frozen while the block is busy. Only the enable bit can be changed at any time. A flush request empties both queues at once.

Top module: `cipher_fifo_dispatch`

## Requirements
- R1: After reset the status word reads 0x00000003 and the configuration readback reads 0.
- R2: Status bit 0 is input-queue empty, bit 1 is input-queue not full, bit 2 is output-queue not empty, bit 3 is output-queue full and bit 4 is busy. Bits 31:5 read 0.
- R3: A block is taken from the input queue only when the queue holds at least one block. A block is 2 words when configuration bit 1 (wide) is 0 and 4 words when it is 1.
- R4: A block is taken only when the output queue has free space for at least one block.
- R5: Results leave the output queue in input order. When configuration bit 2 is 0 (encrypt), each result word is the input word XOR MASK. Every word of a block is written into the output queue on consecutive cycles.
- R6: With wide=1 and direction=1 (decrypt), a key-preparation pass of KEY_LAT cycles runs before the first block after an accepted configuration write. Busy is 1 during that pass, and the input words stay queued until it ends. Later blocks skip the pass.
- R7: While busy is 1, a configuration write changes only bit 0 (enable). Bits 6:1 (wide, direction, key size in bits 4:3, data type in bits 6:5) keep their values. While busy is 0, all seven bits are written.
- R8: Clearing enable blocks new dispatches. A block already in progress still finishes and stores its results before busy drops.
- R9: A flush empties both queues in the next cycle. A block still in the engine is stored afterwards, so the output queue can be non-empty after a flush.
- R10: A push to a full input queue and a pop from an empty output queue are ignored and leave the queue contents and order intact.
- R11: When configuration bit 2 (direction) is 1, each result word is the input word XOR the bitwise complement of MASK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration value: enable, wide, direction, key size, data type |
| cfg_q | output | 7 | Configuration readback |
| flush | input | 1 | Empty both queues |
| in_push | input | 1 | Push in_data into the input queue |
| in_data | input | 32 | Input word |
| out_pop | input | 1 | Pop the head of the output queue |
| out_data | output | 32 | Head word of the output queue (valid when not empty) |
| status | output | 32 | Read-only status word |

## Verification
The bench builds the block with 8-deep queues, a block latency of 6 cycles and a key-preparation latency of 10 cycles. The short latencies make it cheap to land a flush or a configuration write inside a running block. They also leave the key-preparation pass clearly longer than the difference between the two latencies, so the extra delay it adds to the first decrypted block can be measured. Eight-word queues can be filled by four 64-bit blocks or two 128-bit blocks, so both the output-space stall and the full-input case can be reached in a few dozen cycles.

// File: rtl/cfd_pkg.sv
// Package: shared types for the cipher FIFO dispatch controller.
// Assumes at most four 32-bit words per cipher block.
package cfd_pkg;

    localparam int unsigned MAX_BLK = 4;

    // Configuration layout; enable sits at bit 0.
    typedef struct packed {
        logic [1:0] dtype;
        logic [1:0] ksize;
        logic       decrypt;
        logic       wide;
        logic       enable;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KPREP,
        ST_LOAD,
        ST_GO,
        ST_CALC,
        ST_STORE
    } disp_state_t;

endpackage

// File: rtl/cfd_fifo.sv
// Module: cfd_fifo
// Synchronous show-ahead FIFO with a flush. Pushes when full and pops when
// empty are dropped. Flush has priority over push and pop in the same cycle.
// Assumes DEPTH >= 2.
module cfd_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify requests against occupancy and flush.
    always_comb begin
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        rdata   = mem[rd_ptr];
        level   = cnt;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (cnt == $past(cnt))); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty); // R10
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R10

endmodule

// File: rtl/cfd_engine_stub.sv
// Module: cfd_engine_stub
// Placeholder cipher core. A start pulse begins either a key-preparation pass
// (KEY_LAT cycles) or a block pass (BLK_LAT cycles). done pulses for one cycle
// when the pass ends. The block result is the input word XOR MASK for encrypt
// and XOR ~MASK for decrypt. Assumes start is never pulsed while running.
module cfd_engine_stub
    import cfd_pkg::*;
#(
    parameter int unsigned BLK_LAT = 16,
    parameter int unsigned KEY_LAT = 24,
    parameter logic [31:0] MASK    = 32'h5A3C_96E1,
    localparam int unsigned MAXLAT = (BLK_LAT > KEY_LAT) ? BLK_LAT : KEY_LAT,
    localparam int unsigned LW     = $clog2(MAXLAT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      keyprep,
    input  logic                      decrypt,
    input  logic [MAX_BLK-1:0][31:0]  blk_in,
    output logic                      done,
    output logic [MAX_BLK-1:0][31:0]  res
);

    logic          running;
    logic [LW-1:0] cnt;

    // Latency countdown for the pass in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= keyprep ? LW'(KEY_LAT - 1) : LW'(BLK_LAT - 1);
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Capture the stand-in result when a block pass starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else if (start && !keyprep) begin
            for (int w = 0; w < MAX_BLK; w++) begin
                res[w] <= blk_in[w] ^ (decrypt ? ~MASK : MASK);
            end
        end
    end

    // Completion pulse.
    always_comb done = running && (cnt == '0);

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

endmodule

// File: rtl/cfd_dispatch.sv
// Module: cfd_dispatch
// Sequencer that loads a block from the input queue, runs the engine and
// stores the result into the output queue. It waits for a full block of input
// and a block of output space, and inserts a key-preparation pass before the
// first wide decryption. busy is high whenever it is not idle.
// Assumes configuration inputs are stable while busy.
module cfd_dispatch
    import cfd_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      wide,
    input  logic                      decrypt,
    input  logic                      cfg_accept,
    input  logic [CW-1:0]             in_level,
    input  logic [31:0]               in_rdata,
    output logic                      in_pop,
    input  logic [CW-1:0]             out_level,
    output logic                      out_push,
    output logic [31:0]               out_wdata,
    output logic                      eng_start,
    output logic                      eng_keyprep,
    output logic [MAX_BLK-1:0][31:0]  eng_blk,
    input  logic                      eng_done,
    input  logic [MAX_BLK-1:0][31:0]  eng_res,
    output logic                      busy
);

    disp_state_t state;
    logic [1:0]  idx;
    logic [31:0] buf_q [MAX_BLK];
    logic        key_ready;
    logic [CW-1:0] blk_n;
    logic [CW-1:0] out_space;
    logic [1:0]  last_idx;
    logic        go;
    logic        need_key;

    // Dispatch conditions and handshake outputs.
    always_comb begin
        blk_n       = wide ? CW'(4) : CW'(2);
        last_idx    = wide ? 2'd3 : 2'd1;
        out_space   = CW'(DEPTH) - out_level;
        go          = enable && (in_level >= blk_n) && (out_space >= blk_n);
        need_key    = wide && decrypt && !key_ready;
        eng_keyprep = (state == ST_IDLE);
        eng_start   = ((state == ST_IDLE) && go && need_key) || (state == ST_GO);
        in_pop      = (state == ST_LOAD);
        out_push    = (state == ST_STORE);
        out_wdata   = eng_res[idx];
        busy        = (state != ST_IDLE);
        for (int w = 0; w < MAX_BLK; w++) begin
            eng_blk[w] = buf_q[w];
        end
    end

    // Block staging buffer.
    always_ff @(posedge clk) begin
        if (state == ST_LOAD) begin
            buf_q[idx] <= in_rdata;
        end
    end

    // Key-preparation validity; a new configuration forces another pass.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_accept) begin
            key_ready <= 1'b0;
        end else if ((state == ST_KPREP) && eng_done) begin
            key_ready <= 1'b1;
        end
    end

    // Sequencer state and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (go) state <= need_key ? ST_KPREP : ST_LOAD;
                end
                ST_KPREP: if (eng_done) state <= ST_IDLE;
                ST_LOAD: begin
                    idx <= (idx == last_idx) ? 2'd0 : idx + 1'b1;
                    if (idx == last_idx) state <= ST_GO;
                end
                ST_GO:   state <= ST_CALC;
                ST_CALC: if (eng_done) state <= ST_STORE;
                ST_STORE: begin
                    idx <= (idx == last_idx) ? 2'd0 : idx + 1'b1;
                    if (idx == last_idx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DISPATCH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && $past(state) == ST_IDLE) |-> ($past(in_level) >= $past(blk_n))); // R3
    AST_DISPATCH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && $past(state) == ST_IDLE) |-> ($past(out_space) >= $past(blk_n))); // R4
    AST_KEY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && wide && decrypt) |-> key_ready); // R6
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && $past(state) == ST_IDLE) |-> $past(enable)); // R8
    AST_BURST_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_push && idx != last_idx) |=> out_push); // R5

endmodule

// File: rtl/cipher_fifo_dispatch.sv
// Module: cipher_fifo_dispatch (top)
// Input and output word queues around a stub cipher engine, the
// configuration register with its busy lock, and the status word.
// Assumes FIFO_DEPTH >= 4 so that a wide block fits.
module cipher_fifo_dispatch
    import cfd_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned BLK_LAT    = 16,
    parameter int unsigned KEY_LAT    = 24,
    parameter logic [31:0] STUB_MASK  = 32'h5A3C_96E1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [6:0]  cfg_wdata,
    output logic [6:0]  cfg_q,
    input  logic        flush,
    input  logic        in_push,
    input  logic [31:0] in_data,
    input  logic        out_pop,
    output logic [31:0] out_data,
    output logic [31:0] status
);

    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

    cfg_t                     cfg_r;
    logic                     busy;
    logic                     cfg_accept;
    logic [CW-1:0]            in_level;
    logic [CW-1:0]            out_level;
    logic                     in_full, in_empty, out_full, out_empty;
    logic [31:0]              in_rdata;
    logic                     in_pop;
    logic                     out_push;
    logic [31:0]              out_wdata;
    logic                     eng_start, eng_keyprep, eng_done;
    logic [MAX_BLK-1:0][31:0] eng_blk;
    logic [MAX_BLK-1:0][31:0] eng_res;

    // Configuration register; only enable may change while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_r <= '0;
        end else if (cfg_we) begin
            if (busy) cfg_r.enable <= cfg_wdata[0];
            else      cfg_r        <= cfg_t'(cfg_wdata);
        end
    end

    // Readback, write acceptance and status word.
    always_comb begin
        cfg_q      = cfg_r;
        cfg_accept = cfg_we && !busy;
        status     = {27'd0, busy, out_full, !out_empty, !in_full, in_empty};
    end

    cfd_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) i_in_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (in_push),
        .wdata (in_data),
        .pop   (in_pop),
        .rdata (in_rdata),
        .level (in_level),
        .full  (in_full),
        .empty (in_empty)
    );

    cfd_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) i_out_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (out_push),
        .wdata (out_wdata),
        .pop   (out_pop),
        .rdata (out_data),
        .level (out_level),
        .full  (out_full),
        .empty (out_empty)
    );

    cfd_dispatch #(.DEPTH(FIFO_DEPTH)) i_dispatch (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_r.enable),
        .wide        (cfg_r.wide),
        .decrypt     (cfg_r.decrypt),
        .cfg_accept  (cfg_accept),
        .in_level    (in_level),
        .in_rdata    (in_rdata),
        .in_pop      (in_pop),
        .out_level   (out_level),
        .out_push    (out_push),
        .out_wdata   (out_wdata),
        .eng_start   (eng_start),
        .eng_keyprep (eng_keyprep),
        .eng_blk     (eng_blk),
        .eng_done    (eng_done),
        .eng_res     (eng_res),
        .busy        (busy)
    );

    cfd_engine_stub #(.BLK_LAT(BLK_LAT), .KEY_LAT(KEY_LAT), .MASK(STUB_MASK)) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .keyprep (eng_keyprep),
        .decrypt (cfg_r.decrypt),
        .blk_in  (eng_blk),
        .done    (eng_done),
        .res     (eng_res)
    );

    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy) |=> (cfg_q[6:1] == $past(cfg_q[6:1]))); // R7
    AST_FLUSH_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> in_empty); // R9
    AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[31:5] == 27'd0); // R2

endmodule

// File: tb/test_cipher_fifo_dispatch.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_cipher_fifo_dispatch;

    localparam int unsigned DEPTH = 8;
    localparam int unsigned BLAT  = 6;
    localparam int unsigned KLAT  = 10;
    localparam logic [31:0] MASK  = 32'h5A3C_96E1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [6:0]  cfg_wdata;
    logic [6:0]  cfg_q;
    logic        flush;
    logic        in_push;
    logic [31:0] in_data;
    logic        out_pop;
    logic [31:0] out_data;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    cipher_fifo_dispatch #(
        .FIFO_DEPTH(DEPTH), .BLK_LAT(BLAT), .KEY_LAT(KLAT), .STUB_MASK(MASK)
    ) i_cipher_fifo_dispatch (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .flush(flush), .in_push(in_push), .in_data(in_data),
        .out_pop(out_pop), .out_data(out_data), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [6:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        in_push = 1'b1; in_data = w;
        @(negedge clk);
        in_push = 1'b0;
    endtask

    task automatic expect_word(input logic [31:0] w, input logic dec);
        exp_q.push_back(w ^ (dec ? ~MASK : MASK));
    endtask

    task automatic pop_check(input string req);
        logic [31:0] e;
        e = 32'hDEAD_BEEF;
        if (exp_q.size() > 0) e = exp_q.pop_front();
        chk(req, out_data, e);
        out_pop = 1'b1;
        @(negedge clk);
        out_pop = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int t = 0;
        while (quiet < 4 && t < 1000) begin
            @(negedge clk);
            t++;
            quiet = status[4] ? 0 : quiet + 1;
        end
    endtask

    task automatic wait_busy();
        int t = 0;
        while (!status[4] && t < 100) begin
            @(negedge clk);
            t++;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 status", status, 32'h3);
        chk("R1 cfg", {25'd0, cfg_q}, 32'h0);
    endtask

    // R3, R5, R2: narrow encrypt block
    task automatic t_narrow();
        write_cfg(7'h01);
        push_word(32'h1111_0000); expect_word(32'h1111_0000, 1'b0);
        idle(20);
        chk("R3 partial narrow block held", status, 32'h2);
        push_word(32'h2222_0001); expect_word(32'h2222_0001, 1'b0);
        wait_idle();
        chk("R2 status after block", status, 32'h7);
        pop_check("R5 narrow word0");
        pop_check("R5 narrow word1");
        chk("R2 status drained", status, 32'h3);
    endtask

    // R3, R5: wide block needs four words
    task automatic t_wide();
        write_cfg(7'h03);
        for (int i = 0; i < 3; i++) begin
            push_word(32'hA000_0000 + i); expect_word(32'hA000_0000 + i, 1'b0);
        end
        idle(20);
        chk("R3 three words not dispatched in wide", status, 32'h2);
        push_word(32'hA000_0003); expect_word(32'hA000_0003, 1'b0);
        wait_idle();
        for (int i = 0; i < 4; i++) pop_check("R5 wide word");
        chk("R3 wide drained", status, 32'h3);
    endtask

    // R11: decrypt direction uses the complemented mask
    task automatic t_decrypt();
        write_cfg(7'h05);
        push_word(32'h0BAD_F00D); expect_word(32'h0BAD_F00D, 1'b1);
        push_word(32'hCAFE_1234); expect_word(32'hCAFE_1234, 1'b1);
        wait_idle();
        pop_check("R11 decrypt word0");
        pop_check("R11 decrypt word1");
    endtask

    // R4: output space gates dispatch
    task automatic t_space();
        write_cfg(7'h01);
        for (int i = 0; i < 8; i++) begin
            push_word(32'hB000_0000 + i); expect_word(32'hB000_0000 + i, 1'b0);
        end
        wait_idle();
        chk("R2 output full flags", status, 32'hF);
        push_word(32'hB000_0008); expect_word(32'hB000_0008, 1'b0);
        push_word(32'hB000_0009); expect_word(32'hB000_0009, 1'b0);
        idle(30);
        chk("R4 no room, input held", status, 32'hE);
        pop_check("R4 drain 1");
        idle(30);
        chk("R4 one free slot not enough", status, 32'h6);
        pop_check("R4 drain 2");
        wait_idle();
        for (int i = 0; i < 8; i++) pop_check("R4 ordered results");
        chk("R4 drained", status, 32'h3);
    endtask

    // R10: push on full input and pop on empty output ignored
    task automatic t_overflow();
        write_cfg(7'h00);
        for (int i = 0; i < 9; i++) begin
            push_word(32'hC000_0000 + i);
            if (i < 8) expect_word(32'hC000_0000 + i, 1'b0);
        end
        chk("R10 input full flags", status, 32'h0);
        write_cfg(7'h01);
        wait_idle();
        chk("R10 ninth word dropped", status, 32'hF);
        for (int i = 0; i < 8; i++) pop_check("R10 first eight words");
        chk("R10 empty", status, 32'h3);
        out_pop = 1'b1;
        @(negedge clk);
        out_pop = 1'b0;
        chk("R10 pop on empty ignored", status, 32'h3);
        push_word(32'hC100_0000); expect_word(32'hC100_0000, 1'b0);
        push_word(32'hC100_0001); expect_word(32'hC100_0001, 1'b0);
        wait_idle();
        pop_check("R10 pointers intact w0");
        pop_check("R10 pointers intact w1");
    endtask

    // R7: configuration lock while busy
    task automatic t_lock();
        write_cfg(7'h01);
        push_word(32'hD000_0000); expect_word(32'hD000_0000, 1'b0);
        push_word(32'hD000_0001); expect_word(32'hD000_0001, 1'b0);
        wait_busy();
        write_cfg(7'h7F);
        chk("R7 locked fields unchanged", {25'd0, cfg_q}, 32'h01);
        wait_idle();
        pop_check("R7 block kept narrow encrypt w0");
        pop_check("R7 block kept narrow encrypt w1");
        write_cfg(7'h61);
        chk("R7 idle write accepted", {25'd0, cfg_q}, 32'h61);
    endtask

    // R8: disable mid-block
    task automatic t_disable();
        write_cfg(7'h01);
        for (int i = 0; i < 4; i++) begin
            push_word(32'hE000_0000 + i); expect_word(32'hE000_0000 + i, 1'b0);
        end
        wait_busy();
        write_cfg(7'h00);
        chk("R8 enable cleared while busy", {25'd0, cfg_q}, 32'h0);
        wait_idle();
        chk("R8 running block finished, next held", status, 32'h6);
        pop_check("R8 finished w0");
        pop_check("R8 finished w1");
        idle(20);
        chk("R8 no dispatch while disabled", status, 32'h2);
        write_cfg(7'h01);
        wait_idle();
        pop_check("R8 resumed w0");
        pop_check("R8 resumed w1");
    endtask

    // R6: key preparation before first wide decrypt
    task automatic t_keyprep();
        int t1;
        int t2;
        write_cfg(7'h07);
        for (int i = 0; i < 4; i++) begin
            push_word(32'hF000_0000 + i); expect_word(32'hF000_0000 + i, 1'b1);
        end
        idle(3);
        chk("R6 busy in key pass, input kept", status, 32'h12);
        t1 = 3;
        while (!status[2] && t1 < 500) begin @(negedge clk); t1++; end
        wait_idle();
        for (int i = 0; i < 4; i++) pop_check("R6 first decrypt block");
        for (int i = 0; i < 4; i++) begin
            push_word(32'hF100_0000 + i); expect_word(32'hF100_0000 + i, 1'b1);
        end
        t2 = 0;
        while (!status[2] && t2 < 500) begin @(negedge clk); t2++; end
        chk("R6 key pass delay only once", 32'(t1 - t2 >= int'(KLAT)), 32'h1);
        wait_idle();
        for (int i = 0; i < 4; i++) pop_check("R6 second decrypt block");
    endtask

    // R9: flush idle and flush during a block
    task automatic t_flush();
        write_cfg(7'h00);
        for (int i = 0; i < 3; i++) push_word(32'h9000_0000 + i);
        pulse_flush();
        chk("R9 flush empties input", status, 32'h3);
        for (int i = 0; i < 4; i++) push_word(32'h9100_0000 + i);
        expect_word(32'h9100_0000, 1'b0);
        expect_word(32'h9100_0001, 1'b0);
        write_cfg(7'h01);
        wait_busy();
        idle(3);
        pulse_flush();
        chk("R9 input empty after flush in flight", {31'd0, status[0]}, 32'h1);
        wait_idle();
        chk("R9 in-flight results land after flush", status, 32'h7);
        pop_check("R9 in-flight w0");
        pop_check("R9 in-flight w1");
        chk("R9 final", status, 32'h3);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; flush = 1'b0;
        in_push = 1'b0; in_data = '0; out_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_decrypt();
        t_space();
        t_overflow();
        t_lock();
        t_disable();
        t_keyprep();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule